// File: doc/BRIEF.md
# Width-Aware Load/Store Unit

This block sits between a 32-bit integer core and its data memory and carries out one load or store per request. The core presents a base register value, an offset it has already sign-extended from the instruction's immediate, the 3-bit function code of the load or store, a store flag and the store data. The unit adds base and offset into the effective address, decodes the access size, and issues exactly one memory transaction carrying that address, a size code in bytes (1, 2 or 4), the store flag and, for stores, data cut down to the access size.

Data travels right-justified in both directions: a byte occupies bits [7:0] and a halfword bits [15:0], whatever the low address bits are. When the memory answers a load, the unit keeps only the lanes of the access size and fills the upper bits itself, either with copies of the top kept bit or with zeros. One cycle after the memory response it raises a single-cycle completion pulse. A register-write flag rides on that pulse, and the result rides on it too. A function code the unit does not support still completes: the unit raises the pulse at once, writes no register and starts no memory transaction.

Both edges use a request/response handshake. The core side accepts a request while the unit is idle. The memory side holds its request until the memory takes it, and then waits for a response strobe.

Top module: `mem_access_unit`

## Requirements
- R1: After reset the unit is idle: `req_ready` is 1 and `mem_valid`, `done` and `done_wr` are 0.
- R2: `mem_addr` equals `req_base + req_offset` modulo 2^ADDR_W, taken when the request is accepted.
- R3: `mem_width` is 1 for function codes 0 and 4, 2 for codes 1 and 5, and 4 for code 2 on loads. On stores it is 1, 2 and 4 for codes 0, 1 and 2. `mem_store` repeats the request's store flag.
- R4: A load with function code 0 returns `mem_rdata[7:0]` with bits [31:8] copied from bit 7. A load with code 1 returns `mem_rdata[15:0]` with bits [31:16] copied from bit 15.
- R5: A load with function code 4 returns `mem_rdata[7:0]` zero-extended, code 5 returns `mem_rdata[15:0]` zero-extended, and code 2 returns all 32 bits unchanged. Bits of `mem_rdata` above the access size never reach the result.
- R6: A store drives `mem_wdata` with `req_wdata[7:0]` (code 0) or `req_wdata[15:0]` (code 1) and zeros above. Code 2 drives all 32 bits.
- R7: Load codes 3, 6 and 7 and store codes 3 to 7 raise no `mem_valid`. For them, `done` rises in the cycle after acceptance with `done_wr` 0.
- R8: While `mem_valid` is 1 and `mem_ready` is 0, the request stays up with `mem_addr`, `mem_width` and `mem_wdata` unchanged.
- R9: `done` is a one-cycle pulse raised in the cycle after the cycle in which `mem_rvalid` is sampled 1. `req_ready` is 0 from acceptance until after that pulse.
- R10: `done_wr` is 1 with `done` only for supported loads. On a store completion it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents an access |
| req_ready | output | 1 | Unit is idle and takes the access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_funct3 | input | 3 | Size/sign function code |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | ADDR_W | Sign-extended offset |
| req_wdata | input | DATA_W | Store data, right-justified |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory takes the request |
| mem_addr | output | ADDR_W | Effective address |
| mem_width | output | 3 | Access size in bytes: 1, 2 or 4 |
| mem_store | output | 1 | Store flag toward memory |
| mem_wdata | output | DATA_W | Store data cut to size |
| mem_rvalid | input | 1 | Memory response strobe |
| mem_rdata | input | DATA_W | Load data, right-justified |
| done | output | 1 | Access complete, one cycle |
| done_wr | output | 1 | Result is to be written to the register file |
| done_data | output | DATA_W | Extended load result |

## Verification
On every cycle the assertions check the following. The memory request must stay up with fixed fields until it is taken. The size code must be legal. Narrow store data must have its upper bits clear. The completion pulse must last one cycle and, when it carries a write, must follow a memory response. The result of a signed or unsigned byte load must show the right fill. No completion may write a register for a store. The bench scenarios are the only place where the actual arithmetic is shown: the address sum with wrap-around, the size code for each function code, the exact extended values against memory data whose upper bits hold junk, and the handling of unsupported codes. The bench also times completion against variable memory latency.

// File: rtl/mau_pkg.sv
package mau_pkg;

   localparam int WC_W = 3;

   localparam logic [WC_W-1:0] WC_NONE = 3'd0;
   localparam logic [WC_W-1:0] WC_BYTE = 3'd1;
   localparam logic [WC_W-1:0] WC_HALF = 3'd2;
   localparam logic [WC_W-1:0] WC_WORD = 3'd4;

   typedef struct packed {
      logic            ok;
      logic            sext;
      logic [WC_W-1:0] nbytes;
   } mau_access_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } mau_state_t;

endpackage

// File: rtl/mau_decode.sv
module mau_decode
   import mau_pkg::*;
(
   input  logic        is_store,
   input  logic [2:0]  funct3,
   output mau_access_t acc
);

   always_comb begin
      acc = '{ok: 1'b0, sext: 1'b0, nbytes: WC_NONE};
      if (is_store) begin
         unique case (funct3)
            3'd0:    acc = '{ok: 1'b1, sext: 1'b0, nbytes: WC_BYTE};
            3'd1:    acc = '{ok: 1'b1, sext: 1'b0, nbytes: WC_HALF};
            3'd2:    acc = '{ok: 1'b1, sext: 1'b0, nbytes: WC_WORD};
            default: acc = '{ok: 1'b0, sext: 1'b0, nbytes: WC_NONE};
         endcase
      end else begin
         unique case (funct3)
            3'd0:    acc = '{ok: 1'b1, sext: 1'b1, nbytes: WC_BYTE};
            3'd1:    acc = '{ok: 1'b1, sext: 1'b1, nbytes: WC_HALF};
            3'd2:    acc = '{ok: 1'b1, sext: 1'b0, nbytes: WC_WORD};
            3'd4:    acc = '{ok: 1'b1, sext: 1'b0, nbytes: WC_BYTE};
            3'd5:    acc = '{ok: 1'b1, sext: 1'b0, nbytes: WC_HALF};
            default: acc = '{ok: 1'b0, sext: 1'b0, nbytes: WC_NONE};
         endcase
      end
   end

endmodule

// File: rtl/mau_lane_fit.sv
module mau_lane_fit
   import mau_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic [DATA_W-1:0] din,
   input  logic [WC_W-1:0]   nbytes,
   input  logic              sext,
   output logic [DATA_W-1:0] dout
);

   localparam int LANES = DATA_W / 8;

   logic sign_bit;
   logic fill;

   always_comb begin
      unique case (nbytes)
         WC_BYTE: sign_bit = din[7];
         WC_HALF: sign_bit = din[15];
         default: sign_bit = 1'b0;
      endcase
      fill = sext & sign_bit;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic keep;
      assign keep = (nbytes > WC_W'(i));
      assign dout[i*8 +: 8] = keep ? din[i*8 +: 8] : {8{fill}};
   end

endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
   import mau_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_store,
   input  logic [2:0]        req_funct3,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WC_W-1:0]   mem_width,
   output logic              mem_store,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic              done_wr,
   output logic [DATA_W-1:0] done_data
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("mem_access_unit: DATA_W must be 32 for 1/2/4-byte access codes");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("mem_access_unit: ADDR_W must be at least 2");
   end

   mau_state_t  state;
   mau_access_t dec;
   logic        ld_sext;
   logic        wr_pending;
   logic [DATA_W-1:0] st_fit;
   logic [DATA_W-1:0] ld_fit;

   mau_decode u_decode (
      .is_store (req_store),
      .funct3   (req_funct3),
      .acc      (dec)
   );

   mau_lane_fit #(.DATA_W(DATA_W)) u_store_fit (
      .din    (req_wdata),
      .nbytes (dec.nbytes),
      .sext   (1'b0),
      .dout   (st_fit)
   );

   mau_lane_fit #(.DATA_W(DATA_W)) u_load_fit (
      .din    (mem_rdata),
      .nbytes (mem_width),
      .sext   (ld_sext),
      .dout   (ld_fit)
   );

   assign req_ready = (state == ST_IDLE);
   assign mem_valid = (state == ST_ISSUE);
   assign done      = (state == ST_DONE);
   assign done_wr   = done & wr_pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         mem_addr   <= '0;
         mem_width  <= WC_NONE;
         mem_store  <= 1'b0;
         mem_wdata  <= '0;
         ld_sext    <= 1'b0;
         wr_pending <= 1'b0;
         done_data  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  mem_addr   <= req_base + req_offset;
                  mem_width  <= dec.nbytes;
                  mem_store  <= req_store;
                  mem_wdata  <= req_store ? st_fit : '0;
                  ld_sext    <= dec.sext;
                  wr_pending <= dec.ok & ~req_store;
                  done_data  <= '0;
                  state      <= dec.ok ? ST_ISSUE : ST_DONE;
               end
            end
            ST_ISSUE: begin
               if (mem_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rvalid) begin
                  done_data <= mem_store ? '0 : ld_fit;
                  state     <= ST_DONE;
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/mau_checker.sv
module mau_checker
   import mau_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_store,
   input logic [2:0]        req_funct3,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WC_W-1:0]   mem_width,
   input logic              mem_store,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_rvalid,
   input logic              done,
   input logic              done_wr,
   input logic [DATA_W-1:0] done_data
);

   logic       cap_store;
   logic [2:0] cap_f3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_store <= 1'b0;
         cap_f3    <= 3'd0;
      end else if (req_valid && req_ready) begin
         cap_store <= req_store;
         cap_f3    <= req_funct3;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_width) && $stable(mem_wdata)); // R8

   AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_width == WC_BYTE || mem_width == WC_HALF || mem_width == WC_WORD)); // R3

   AST_STORE_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_store && mem_width == WC_BYTE |-> mem_wdata[DATA_W-1:8] == '0); // R6

   AST_STORE_HALF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_store && mem_width == WC_HALF |-> mem_wdata[DATA_W-1:16] == '0); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_WRITE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_wr |-> $past(mem_rvalid)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_valid && !done); // R9

   AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done && cap_store |-> !done_wr); // R10

   AST_SIGNED_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_wr && cap_f3 == 3'd0 |-> done_data[DATA_W-1:8] == {(DATA_W-8){done_data[7]}}); // R4

   AST_UNSIGNED_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_wr && cap_f3 == 3'd4 |-> done_data[DATA_W-1:8] == '0); // R5

endmodule

bind mem_access_unit mau_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mau_checker (.*);

// File: tb/test_mem_access_unit.sv
`timescale 1ns/1ps
module test_mem_access_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_store = 1'b0;
   logic [2:0]  req_funct3 = 3'd0;
   logic [31:0] req_base = '0;
   logic [31:0] req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_addr;
   logic [2:0]  mem_width;
   logic        mem_store;
   logic [31:0] mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done;
   logic        done_wr;
   logic [31:0] done_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mem_access_unit i_mem_access_unit (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit f_ok(input bit st, input logic [2:0] f3);
      if (st) return f3 <= 3'd2;
      return f3 inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5};
   endfunction

   function automatic logic [2:0] f_width(input logic [2:0] f3);
      case (f3)
         3'd0, 3'd4: return 3'd1;
         3'd1, 3'd5: return 3'd2;
         default:    return 3'd4;
      endcase
   endfunction

   function automatic logic [31:0] f_load(input logic [2:0] f3, input logic [31:0] d);
      case (f3)
         3'd0:    return {{24{d[7]}}, d[7:0]};
         3'd1:    return {{16{d[15]}}, d[15:0]};
         3'd4:    return {24'd0, d[7:0]};
         3'd5:    return {16'd0, d[15:0]};
         default: return d;
      endcase
   endfunction

   function automatic logic [31:0] f_store(input logic [2:0] f3, input logic [31:0] d);
      case (f3)
         3'd0:    return {24'd0, d[7:0]};
         3'd1:    return {16'd0, d[15:0]};
         default: return d;
      endcase
   endfunction

   task automatic run_op(input bit st, input logic [2:0] f3, input logic [31:0] base,
                         input logic [31:0] off, input logic [31:0] wd, input logic [31:0] rd,
                         input int d1, input int d2);
      logic [31:0] exp_addr;
      exp_addr = base + off;
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_funct3 = f3;
      req_base = base; req_offset = off; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_base = $urandom; req_offset = $urandom; req_wdata = $urandom;
      if (f_ok(st, f3)) begin
         chk("R9 ready low while busy", {31'd0, req_ready}, 32'd0);
         chk("R2 effective address", mem_addr, exp_addr);
         chk("R3 width code", {29'd0, mem_width}, {29'd0, f_width(f3)});
         chk("R3 store flag", {31'd0, mem_store}, {31'd0, st});
         if (st) chk("R6 store data mask", mem_wdata, f_store(f3, wd));
         for (int k = 0; k < d1; k++) begin
            @(negedge clk);
            chk("R8 request held", {31'd0, mem_valid}, 32'd1);
            chk("R8 address held", mem_addr, exp_addr);
         end
         mem_ready = 1'b1;
         @(negedge clk);
         mem_ready = 1'b0;
         chk("R8 request dropped after accept", {31'd0, mem_valid}, 32'd0);
         for (int k = 0; k < d2; k++) begin
            chk("R9 no early done", {31'd0, done}, 32'd0);
            @(negedge clk);
         end
         mem_rvalid = 1'b1; mem_rdata = rd;
         @(negedge clk);
         mem_rvalid = 1'b0; mem_rdata = $urandom;
         chk("R9 done after response", {31'd0, done}, 32'd1);
         if (st) begin
            chk("R10 no write on store", {31'd0, done_wr}, 32'd0);
         end else begin
            chk("R10 write on load", {31'd0, done_wr}, 32'd1);
            if (f3 == 3'd0 || f3 == 3'd1) chk("R4 signed load", done_data, f_load(f3, rd));
            else                          chk("R5 unsigned/word load", done_data, f_load(f3, rd));
         end
      end else begin
         chk("R7 no bus transaction", {31'd0, mem_valid}, 32'd0);
         chk("R7 done raised", {31'd0, done}, 32'd1);
         chk("R7 no register write", {31'd0, done_wr}, 32'd0);
      end
      @(negedge clk);
      chk("R9 done single pulse", {31'd0, done}, 32'd0);
      chk("R9 ready after completion", {31'd0, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
      chk("R1 reset mem_valid", {31'd0, mem_valid}, 32'd0);
      chk("R1 reset done", {30'd0, done, done_wr}, 32'd0);
      rst_n = 1'b1;

      // directed corner cases
      run_op(1'b0, 3'd0, 32'h1000, 32'h4, 32'h0, 32'hABCD_EF80, 0, 0); // R4 negative byte
      run_op(1'b0, 3'd1, 32'h2000, 32'hFFFF_FFFE, 32'h0, 32'h1234_8001, 1, 2); // R4 negative half
      run_op(1'b0, 3'd1, 32'h2000, 32'h2, 32'h0, 32'hFFFF_7FFF, 0, 1); // R4 positive half
      run_op(1'b0, 3'd4, 32'h30, 32'h0, 32'h0, 32'h5555_55FF, 2, 0); // R5 unsigned byte
      run_op(1'b0, 3'd5, 32'h30, 32'h2, 32'h0, 32'hFFFF_FFFF, 0, 0); // R5 unsigned half
      run_op(1'b0, 3'd2, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h8000_0001, 0, 0); // R2 wrap, R5 word
      run_op(1'b1, 3'd0, 32'h40, 32'h7FF, 32'hFFFF_FFFF, 32'h0, 1, 1); // R6 byte store
      run_op(1'b1, 3'd1, 32'h40, 32'hFFFF_F800, 32'hDEAD_BEEF, 32'h0, 0, 0); // R6 half store
      run_op(1'b1, 3'd2, 32'h40, 32'h8, 32'hDEAD_BEEF, 32'h0, 0, 0); // R6 word store
      run_op(1'b0, 3'd3, 32'h50, 32'h0, 32'h0, 32'h0, 0, 0); // R7 unsupported load
      run_op(1'b0, 3'd7, 32'h50, 32'h0, 32'h0, 32'h0, 0, 0); // R7 unsupported load
      run_op(1'b1, 3'd5, 32'h50, 32'h0, 32'h1, 32'h0, 0, 0); // R7 unsupported store

      // constrained random
      for (int n = 0; n < 400; n++) begin
         logic [31:0] imm;
         imm = $urandom;
         run_op(1'($urandom), 3'($urandom), $urandom, {{20{imm[11]}}, imm[11:0]},
                $urandom, $urandom, int'($urandom % 3), int'($urandom % 3));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule